// File: doc/BRIEF.md
# ISA Master Ready Responder

This block is the target-side ready logic for a bridge that external 16-bit ISA bus masters can reach. It watches the four command strobes (memory read, memory write, I/O read, I/O write) and passes them through a two-flop synchroniser. When an external master owns the bus and the decode input says the access belongs to this bridge, the block drives the open-drain channel-ready line low. This adds wait states. The line stays low until read data is valid or write data has been captured. The block then drives the line high for a short fixed pulse and releases it. The whole high-drive-plus-release window fits in 70 ns.

The block also drives the 16-bit memory chip-select line low while an external master runs a memory cycle that goes to the host memory side. Both lines are tri-state and use an enable/value pair. A pull-up outside the block sets their level whenever the enable is low. Bus arbitration, address decoding and the data path are outside the block. Their results come in as plain inputs.

The controller has five states. ST_IDLE waits for a fresh synchronised command edge. ST_HOLD_LOW drives the line low. ST_PULSE_HIGH drives it high for a counted number of cycles. ST_RELEASE is one float cycle. ST_WAIT_END floats until the strobe negates. The transitions are:
- claim: IDLE to HOLD_LOW.
- abort: HOLD_LOW to IDLE when the strobe negates early.
- complete: HOLD_LOW to PULSE_HIGH.
- expire: PULSE_HIGH to RELEASE when the counter runs out.
- finish: RELEASE or WAIT_END to IDLE when the strobe negates.
- linger: RELEASE to WAIT_END while the strobe is still held.
- sleep: any state to IDLE.

Top module: `isa_rdy_responder`

## Requirements
- R1: While rst_n is low, rdy_oe_o and mcs16_oe_o are 0.
- R2: A claimed cycle drives the ready line low (rdy_oe_o=1, rdy_val_o=0). A cycle is claimed when a command strobe falls (no strobe was low before), ext_master_i=1 and hit_i=1. The low drive starts on the third rising clock edge after the strobe falls: two synchroniser edges and one edge for the state register.
- R3: The low drive holds until the completion indication is sampled high. For a read cycle (memory read or I/O read strobe low at the claim) the indication is data_rdy_i. For a write cycle it is wr_latched_i. The other indication has no effect.
- R4: On the edge that samples completion, the line switches to high drive (rdy_oe_o=1, rdy_val_o=1). High drive lasts exactly HI = floor(WINDOW_PS/CLK_PERIOD_PS) - 1 cycles (minimum 1). It is followed by at least one float cycle, so HI+1 cycles fit inside the window.
- R5: After the pulse the line floats while the strobe stays low, and further completion pulses do not re-drive it. A new cycle needs a fresh falling edge.
- R6: No drive of the ready line happens for a cycle seen while ext_master_i=0 or hit_i=0.
- R7: If the synchronised strobe negates while the line is held low, the cycle is aborted and the line floats from the next edge.
- R8: While sleep_i is 1, both enables are 0 in the same cycle, and the controller returns to idle.
- R9: mcs16_oe_o is 1 with mcs16_val_o=0 from the third edge after a memory strobe falls, as long as ext_master_i=1, host_mem_i=1 and sleep_i=0 (inputs sampled each edge). It is 0 during I/O-only cycles and otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Power-down state: forces both lines to float |
| ext_master_i | input | 1 | An external master owns the bus |
| memr_n_i | input | 1 | Memory read strobe, active low, asynchronous |
| memw_n_i | input | 1 | Memory write strobe, active low, asynchronous |
| ior_n_i | input | 1 | I/O read strobe, active low, asynchronous |
| iow_n_i | input | 1 | I/O write strobe, active low, asynchronous |
| hit_i | input | 1 | The current access targets this bridge |
| host_mem_i | input | 1 | The memory access is forwarded to host memory |
| data_rdy_i | input | 1 | Read data is valid on the bus |
| wr_latched_i | input | 1 | Write data has been captured |
| rdy_oe_o | output | 1 | Ready line drive enable |
| rdy_val_o | output | 1 | Ready line drive value |
| mcs16_oe_o | output | 1 | Memory chip-select drive enable |
| mcs16_val_o | output | 1 | Memory chip-select drive value (always low) |

## Verification
A strobe change reaches either drive enable on the third rising edge after it, because the synchroniser and the state register each add one edge. Completion and the decode inputs take effect on the first edge that samples them. Sleep acts on the enables within the same cycle. The bench drives inputs just after a rising edge. A behavioural model updates on the same edges with these latencies, and the outputs are compared at every falling edge. Directed checks also count the edges to the first low drive and the length of the high pulse.

// File: rtl/isa_rdy_pkg.sv
package isa_rdy_pkg;

    // strobe bit positions inside the packed command vector
    localparam int unsigned CMD_MEMR = 0;
    localparam int unsigned CMD_MEMW = 1;
    localparam int unsigned CMD_IOR  = 2;
    localparam int unsigned CMD_IOW  = 3;
    localparam int unsigned CMD_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_LOW,
        ST_PULSE_HIGH,
        ST_RELEASE,
        ST_WAIT_END
    } rdy_state_e;

    // high-drive cycles so that drive plus one release cycle fit the window
    function automatic int calc_hi_cycles(input int period_ps, input int window_ps);
        int n;
        n = (window_ps / period_ps) - 1;
        if (n < 1) n = 1;
        return n;
    endfunction

endpackage

// File: rtl/isa_strobe_sync.sv
module isa_strobe_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_n_i,
    output logic [WIDTH-1:0] sync_n_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw_n_i[b]};
        end
        assign sync_n_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/isa_cmd_edge.sv
module isa_cmd_edge
    import isa_rdy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  sync_n_i,
    output logic              cmd_act_o,
    output logic              cmd_fall_o,
    output logic              is_read_o,
    output logic              mem_act_o
);

    logic act_prev_q;

    assign cmd_act_o  = ~(&sync_n_i);
    assign cmd_fall_o = cmd_act_o & ~act_prev_q;
    assign is_read_o  = ~sync_n_i[CMD_MEMR] | ~sync_n_i[CMD_IOR];
    assign mem_act_o  = ~sync_n_i[CMD_MEMR] | ~sync_n_i[CMD_MEMW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_prev_q <= 1'b0;
        else        act_prev_q <= cmd_act_o;
    end

endmodule

// File: rtl/isa_rdy_fsm.sv
module isa_rdy_fsm
    import isa_rdy_pkg::*;
#(
    parameter int unsigned HI_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic cmd_act_i,
    input  logic cmd_fall_i,
    input  logic is_read_i,
    input  logic ext_master_i,
    input  logic hit_i,
    input  logic data_rdy_i,
    input  logic wr_latched_i,
    output logic drive_o,
    output logic level_o
);

    localparam int unsigned CW = (HI_CYC > 1) ? $clog2(HI_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(HI_CYC - 1);

    rdy_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          kind_rd_q, kind_rd_d;
    logic          done_ind;

    assign done_ind = kind_rd_q ? data_rdy_i : wr_latched_i;

    // next-state and datapath decisions
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        kind_rd_d = kind_rd_q;
        if (sleep_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_fall_i && ext_master_i && hit_i) begin
                        state_d   = ST_HOLD_LOW;
                        kind_rd_d = is_read_i;
                    end
                end
                ST_HOLD_LOW: begin
                    if (!cmd_act_i) begin
                        state_d = ST_IDLE;
                    end else if (done_ind) begin
                        state_d = ST_PULSE_HIGH;
                        cnt_d   = CNT_LOAD;
                    end
                end
                ST_PULSE_HIGH: begin
                    if (cnt_q == '0) state_d = ST_RELEASE;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_RELEASE: begin
                    state_d = cmd_act_i ? ST_WAIT_END : ST_IDLE;
                end
                ST_WAIT_END: begin
                    if (!cmd_act_i) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            kind_rd_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            kind_rd_q <= kind_rd_d;
        end
    end

    // outputs
    always_comb begin
        drive_o = 1'b0;
        level_o = 1'b0;
        unique case (state_q)
            ST_HOLD_LOW:   drive_o = 1'b1;
            ST_PULSE_HIGH: begin
                drive_o = 1'b1;
                level_o = 1'b1;
            end
            ST_IDLE, ST_RELEASE, ST_WAIT_END: drive_o = 1'b0;
            default:       drive_o = 1'b0;
        endcase
        if (sleep_i) drive_o = 1'b0;
    end

endmodule

// File: rtl/isa_mcs16_drv.sv
module isa_mcs16_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic ext_master_i,
    input  logic host_mem_i,
    input  logic mem_act_i,
    output logic oe_o,
    output logic val_o
);

    logic claim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) claim_q <= 1'b0;
        else        claim_q <= ~sleep_i & ext_master_i & host_mem_i & mem_act_i;
    end

    assign oe_o  = claim_q & ~sleep_i;
    assign val_o = 1'b0;

endmodule

// File: rtl/isa_rdy_responder.sv
module isa_rdy_responder
    import isa_rdy_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 15000,
    parameter int WINDOW_PS     = 70000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic ext_master_i,
    input  logic memr_n_i,
    input  logic memw_n_i,
    input  logic ior_n_i,
    input  logic iow_n_i,
    input  logic hit_i,
    input  logic host_mem_i,
    input  logic data_rdy_i,
    input  logic wr_latched_i,
    output logic rdy_oe_o,
    output logic rdy_val_o,
    output logic mcs16_oe_o,
    output logic mcs16_val_o
);

    localparam int unsigned HI_CYC = calc_hi_cycles(CLK_PERIOD_PS, WINDOW_PS);

    logic [CMD_W-1:0] raw_n, sync_n;
    logic cmd_act, cmd_fall, is_read, mem_act;

    always_comb begin
        raw_n           = '1;
        raw_n[CMD_MEMR] = memr_n_i;
        raw_n[CMD_MEMW] = memw_n_i;
        raw_n[CMD_IOR]  = ior_n_i;
        raw_n[CMD_IOW]  = iow_n_i;
    end

    isa_strobe_sync #(.WIDTH(CMD_W), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_n_i  (raw_n),
        .sync_n_o (sync_n)
    );

    isa_cmd_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_n_i   (sync_n),
        .cmd_act_o  (cmd_act),
        .cmd_fall_o (cmd_fall),
        .is_read_o  (is_read),
        .mem_act_o  (mem_act)
    );

    isa_rdy_fsm #(.HI_CYC(HI_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .cmd_act_i    (cmd_act),
        .cmd_fall_i   (cmd_fall),
        .is_read_i    (is_read),
        .ext_master_i (ext_master_i),
        .hit_i        (hit_i),
        .data_rdy_i   (data_rdy_i),
        .wr_latched_i (wr_latched_i),
        .drive_o      (rdy_oe_o),
        .level_o      (rdy_val_o)
    );

    isa_mcs16_drv u_mcs (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .ext_master_i (ext_master_i),
        .host_mem_i   (host_mem_i),
        .mem_act_i    (mem_act),
        .oe_o         (mcs16_oe_o),
        .val_o        (mcs16_val_o)
    );

endmodule

// File: rtl/isa_rdy_responder_chk.sv
module isa_rdy_responder_chk
    import isa_rdy_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 15000,
    parameter int WINDOW_PS     = 70000
) (
    input logic clk,
    input logic rst_n,
    input logic sleep_i,
    input logic ext_master_i,
    input logic hit_i,
    input logic rdy_oe_o,
    input logic rdy_val_o,
    input logic mcs16_oe_o,
    input logic mcs16_val_o
);

    localparam int unsigned HI_CYC = calc_hi_cycles(CLK_PERIOD_PS, WINDOW_PS);

    logic [15:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      hi_run_q <= '0;
        else if (rdy_oe_o && rdy_val_o) hi_run_q <= (hi_run_q == 16'hFFFF) ? hi_run_q : hi_run_q + 1'b1;
        else                             hi_run_q <= '0;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!rdy_oe_o && !mcs16_oe_o));

    p_pulse_from_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe_o && rdy_val_o && !$past(rdy_oe_o && rdy_val_o)) |-> ($past(rdy_oe_o) && !$past(rdy_val_o)));

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe_o && rdy_val_o) |-> (hi_run_q < 16'(HI_CYC)));

    p_float_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rdy_oe_o) && $past(rdy_val_o)) |=> !rdy_oe_o);

    p_claim_needs_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy_oe_o) && !$past(sleep_i)) |-> $past(ext_master_i && hit_i));

    p_sleep_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (!rdy_oe_o && !mcs16_oe_o));

    p_mcs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mcs16_oe_o |-> !mcs16_val_o);

endmodule

bind isa_rdy_responder isa_rdy_responder_chk #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .WINDOW_PS     (WINDOW_PS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_i      (sleep_i),
    .ext_master_i (ext_master_i),
    .hit_i        (hit_i),
    .rdy_oe_o     (rdy_oe_o),
    .rdy_val_o    (rdy_val_o),
    .mcs16_oe_o   (mcs16_oe_o),
    .mcs16_val_o  (mcs16_val_o)
);

// File: tb/isa_rdy_responder_test.sv
`timescale 1ns/1ps
module isa_rdy_responder_test;

    localparam int PERIOD_NS = 16;
    localparam int WIN_PS    = 70000;
    localparam int HI        = (WIN_PS / (PERIOD_NS * 1000)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 1'b0, ext_master_i = 1'b0, hit_i = 1'b0, host_mem_i = 1'b0;
    logic memr_n_i = 1'b1, memw_n_i = 1'b1, ior_n_i = 1'b1, iow_n_i = 1'b1;
    logic data_rdy_i = 1'b0, wr_latched_i = 1'b0;
    logic rdy_oe_o, rdy_val_o, mcs16_oe_o, mcs16_val_o;

    int total = 0;
    int bad = 0;
    bit run = 0;
    bit ended = 0;
    string cur_req = "R1";

    always #(PERIOD_NS/2) clk = ~clk;

    isa_rdy_responder #(.CLK_PERIOD_PS(PERIOD_NS*1000), .WINDOW_PS(WIN_PS)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ext_master_i(ext_master_i),
        .memr_n_i(memr_n_i), .memw_n_i(memw_n_i), .ior_n_i(ior_n_i), .iow_n_i(iow_n_i),
        .hit_i(hit_i), .host_mem_i(host_mem_i), .data_rdy_i(data_rdy_i),
        .wr_latched_i(wr_latched_i), .rdy_oe_o(rdy_oe_o), .rdy_val_o(rdy_val_o),
        .mcs16_oe_o(mcs16_oe_o), .mcs16_val_o(mcs16_val_o)
    );

    // behavioural reference: strobe history queue plus phase bookkeeping
    logic [3:0] hist [$];
    bit   prev_act = 0, kind_rd = 0, mcs_q = 0;
    int   phase = 0, hi_left = 0;

    initial begin
        hist.push_back(4'hF);
        hist.push_back(4'hF);
    end

    always @(posedge clk) begin
        logic [3:0] seen;
        bit act, fall, rd, mem;
        if (!rst_n) begin
            hist.delete();
            hist.push_back(4'hF);
            hist.push_back(4'hF);
            prev_act = 0; phase = 0; hi_left = 0; mcs_q = 0; kind_rd = 0;
        end else begin
            seen = hist[0];
            act  = (seen != 4'hF);
            fall = act && !prev_act;
            rd   = !seen[0] || !seen[2];
            mem  = !seen[0] || !seen[1];
            mcs_q = ext_master_i && host_mem_i && mem && !sleep_i;
            if (sleep_i) phase = 0;
            else if (phase == 0) begin
                if (fall && ext_master_i && hit_i) begin phase = 1; kind_rd = rd; end
            end else if (phase == 1) begin
                if (!act) phase = 0;
                else if (kind_rd ? data_rdy_i : wr_latched_i) begin phase = 2; hi_left = HI; end
            end else if (phase == 2) begin
                hi_left = hi_left - 1;
                if (hi_left == 0) phase = 3;
            end else if (!act) phase = 0;
            prev_act = act;
            void'(hist.pop_front());
            hist.push_back({iow_n_i, ior_n_i, memw_n_i, memr_n_i});
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        bit e_oe, e_moe;
        if (rst_n && run) begin
            e_oe  = (phase == 1 || phase == 2) && !sleep_i;
            e_moe = mcs_q && !sleep_i;
            check(rdy_oe_o == e_oe, cur_req, "ready enable", rdy_oe_o, e_oe);
            if (e_oe) check(rdy_val_o == (phase == 2), cur_req, "ready value", rdy_val_o, phase == 2);
            check(mcs16_oe_o == e_moe, sleep_i ? "R8" : "R9", "chip-select enable", mcs16_oe_o, e_moe);
            if (mcs16_oe_o) check(mcs16_val_o == 1'b0, "R9", "chip-select value", mcs16_val_o, 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_up;
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD_NS * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        int n_hi;
        // R1: reset with live stimulus
        ext_master_i = 1; hit_i = 1; host_mem_i = 1; memr_n_i = 0;
        tick(4);
        @(negedge clk);
        check(!rdy_oe_o, "R1", "ready enable in reset", rdy_oe_o, 0);
        check(!mcs16_oe_o, "R1", "chip-select enable in reset", mcs16_oe_o, 0);
        tick(1);
        memr_n_i = 1; host_mem_i = 0;
        tick(1);
        rst_n = 1; run = 1;
        tick(4);

        // R2: memory read claim latency
        cur_req = "R2";
        memr_n_i = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(!rdy_oe_o, "R2", "enable after two edges", rdy_oe_o, 0);
        @(posedge clk);
        @(negedge clk);
        check(rdy_oe_o && !rdy_val_o, "R2", "low drive after third edge", {rdy_oe_o, rdy_val_o}, 2);

        // R3: write indication ignored during a read
        cur_req = "R3";
        tick(3);
        wr_latched_i = 1; tick(2); wr_latched_i = 0; tick(2);
        @(negedge clk);
        check(rdy_oe_o && !rdy_val_o, "R3", "still held low", {rdy_oe_o, rdy_val_o}, 2);
        tick(1);

        // R4: pulse length
        cur_req = "R4";
        data_rdy_i = 1; tick(1); data_rdy_i = 0;
        n_hi = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rdy_oe_o && rdy_val_o) n_hi++;
        end
        check(n_hi == HI, "R4", "high drive cycles", n_hi, HI);

        // R5: no re-drive while strobe held
        cur_req = "R5";
        tick(2);
        data_rdy_i = 1; tick(2); data_rdy_i = 0; tick(2);
        @(negedge clk);
        check(!rdy_oe_o, "R5", "floating after pulse", rdy_oe_o, 0);
        tick(1);
        memr_n_i = 1; tick(4);

        // R3: I/O write completes on write indication only
        cur_req = "R3";
        iow_n_i = 0; tick(5);
        data_rdy_i = 1; tick(2); data_rdy_i = 0; tick(2);
        wr_latched_i = 1; tick(1); wr_latched_i = 0; tick(6);
        iow_n_i = 1; tick(4);

        // R6: foreign slave and no ownership
        cur_req = "R6";
        hit_i = 0; memr_n_i = 0; tick(8);
        @(negedge clk);
        check(!rdy_oe_o, "R6", "no drive for foreign slave", rdy_oe_o, 0);
        tick(1);
        memr_n_i = 1; tick(3);
        hit_i = 1; ext_master_i = 0; host_mem_i = 1; memw_n_i = 0; tick(8);
        @(negedge clk);
        check(!rdy_oe_o, "R6", "no drive without ownership", rdy_oe_o, 0);
        check(!mcs16_oe_o, "R9", "no chip-select without ownership", mcs16_oe_o, 0);
        tick(1);
        memw_n_i = 1; host_mem_i = 0; ext_master_i = 1; tick(4);

        // R7: abort
        cur_req = "R7";
        ior_n_i = 0; tick(6);
        ior_n_i = 1; tick(4);
        @(negedge clk);
        check(!rdy_oe_o, "R7", "float after abort", rdy_oe_o, 0);
        tick(1);

        // R8: sleep mid-cycle
        cur_req = "R8";
        memr_n_i = 0; host_mem_i = 1; tick(5);
        sleep_i = 1; #1;
        check(!rdy_oe_o && !mcs16_oe_o, "R8", "float in sleep", {rdy_oe_o, mcs16_oe_o}, 0);
        tick(2);
        data_rdy_i = 1; tick(1); data_rdy_i = 0;
        sleep_i = 0; tick(4);
        @(negedge clk);
        check(!rdy_oe_o, "R8", "idle after sleep", rdy_oe_o, 0);
        tick(1);
        memr_n_i = 1; host_mem_i = 0; tick(4);

        // R9: chip select for host memory, not for I/O
        cur_req = "R9";
        host_mem_i = 1; hit_i = 0; memw_n_i = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(!mcs16_oe_o, "R9", "chip-select before third edge", mcs16_oe_o, 0);
        @(posedge clk);
        @(negedge clk);
        check(mcs16_oe_o && !mcs16_val_o, "R9", "chip-select driven low", {mcs16_oe_o, mcs16_val_o}, 2);
        tick(3);
        memw_n_i = 1; tick(4);
        ior_n_i = 0; tick(6);
        @(negedge clk);
        check(!mcs16_oe_o, "R9", "no chip-select on I/O", mcs16_oe_o, 0);
        tick(1);
        ior_n_i = 1; tick(4);

        run = 0;
        finish_up();
    end

endmodule